// File: doc/BRIEF.md
# USB IN Packet Gathering Controller

This block sits between software that writes bytes one at a time and a USB device endpoint that sends bulk IN packets to the host. Each accepted byte goes into a 32-entry, 8-bit transmit FIFO. The block then decides when the queued bytes count as a packet that can go to the host. This happens in one of two ways:

- At once, when a full 32-byte packet is waiting.
- After a short quiet gap with no new writes while at least one byte is pending. Short bursts are therefore gathered into one packet instead of being sent a byte at a time.

When the host's IN request arrives and a packet is ready, the block latches the packet length. It then streams the bytes out on a valid/ready interface and marks the final byte. An IN request with nothing ready is answered with a one-cycle NAK pulse.

In loopback mode the FIFO drains into a separate valid/ready stream that feeds the receive path. The USB side then never sees a ready packet. A clear input empties the FIFO and abandons any packet in flight.

Both streams follow valid/ready rules. Valid stays high and data and last stay unchanged until ready is seen high on a clock edge. A byte is transferred on every edge where both are high. On the write side, `wr_ready` is low only when the FIFO is full. A write offered while full is not held back: it is dropped and flagged.

Top module: `usb_in_gather`

## Requirements
- R1: After reset the FIFO is empty: `level` is 0, `empty` is 1, and `full`, `pkt_rdy`, `pkt_valid`, `lb_valid`, `in_nak` and `overflow` are all 0.
- R2: A write offered while `level` is below 32 is accepted. `level` rises by one for each accepted write without a concurrent pop. `full` is 1 exactly when `level` is 32, and `wr_ready` is its inverse.
- R3: A write offered while the FIFO holds 32 bytes is dropped. `level` is unchanged, and `overflow` is 1 in the following cycle only.
- R4: With loopback off and no transfer running, `pkt_rdy` is 1 in the same cycle that `level` reaches 32.
- R5: With 1 to 31 bytes queued, `pkt_rdy` rises once 168 clock edges have passed since the last accepted write, and not earlier. Each accepted write restarts this count.
- R6: An IN request (`in_req` high for one cycle) while `pkt_rdy` is 0 produces `in_nak` high in the next cycle, and nothing is streamed.
- R7: An IN request while `pkt_rdy` is 1 makes `pkt_valid` high from the next cycle. The latched packet length is min(`level`, 32). Bytes come out in write order, and `pkt_last` is high on the final byte. While `pkt_ready` is low, `pkt_data` and `pkt_last` hold their values.
- R8: Bytes accepted while a packet is streaming are not part of it. They remain in the FIFO for the next packet.
- R9: With `loopback_en` high, `pkt_rdy` stays 0, IN requests get a NAK, and the queued bytes leave in write order on `lb_valid`/`lb_data`.
- R10: A one-cycle `fifo_clr` pulse empties the FIFO. It also ends any packet in flight, so `pkt_valid` is 0 in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock (timer threshold counted in its cycles) |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_valid | input | 1 | Software write strobe |
| wr_data | input | 8 | Byte to queue |
| wr_ready | output | 1 | FIFO has room for the byte |
| fifo_clr | input | 1 | Empty the FIFO and abort any transfer |
| loopback_en | input | 1 | Divert FIFO bytes to the receive stream |
| level | output | 6 | Current fill count, 0 to 32 |
| full | output | 1 | FIFO holds 32 bytes |
| empty | output | 1 | FIFO holds no bytes |
| overflow | output | 1 | One-cycle flag for a dropped write |
| pkt_rdy | output | 1 | A packet is ready for the next IN request |
| in_req | input | 1 | IN request from the host for this endpoint |
| in_nak | output | 1 | One-cycle NAK answer to an IN request |
| pkt_valid | output | 1 | Packet byte available |
| pkt_data | output | 8 | Packet byte |
| pkt_last | output | 1 | Final byte of the packet |
| pkt_ready | input | 1 | Packet consumer accepts the byte |
| lb_valid | output | 1 | Loopback byte available |
| lb_data | output | 8 | Loopback byte |
| lb_ready | input | 1 | Receive path accepts the loopback byte |

## Verification
On every cycle, the checker enforces:
- the one-cycle overflow response to a refused write;
- the level step for a plain write;
- immediate readiness at a full packet;
- a NAK after an unready IN request;
- held data while a packet byte is stalled;
- the end of the stream after the last byte;
- mutual exclusion of the packet and loopback streams.

Only the bench scenarios can show the exact 168-edge gathering boundary and its restart on each new write. The same holds for the order and count of bytes in a packet, bytes written mid-transfer landing in the next packet, and the loopback byte order.

// File: rtl/usb_in_gather_pkg.sv
package usb_in_gather_pkg;

  typedef enum logic {
    GS_IDLE = 1'b0,
    GS_SEND = 1'b1
  } gather_state_e;

  function automatic int unsigned min_u(input int unsigned a, input int unsigned b);
    return (a < b) ? a : b;
  endfunction

endpackage

// File: rtl/tx_byte_fifo.sv
module tx_byte_fifo #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 32,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              push,
  input  logic [DATA_W-1:0] wdata,
  input  logic              pop,
  output logic [DATA_W-1:0] rdata,
  output logic [LVL_W-1:0]  level,
  output logic              full,
  output logic              empty
);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wr_ptr, rd_ptr;
  logic [PTR_W-1:0]  wr_ptr_nx, rd_ptr_nx;
  logic [LVL_W-1:0]  cnt_q;

  // Pointer advance: free wrap for power-of-two depth, compare otherwise.
  generate
    if ((DEPTH & (DEPTH - 1)) == 0) begin : g_pow2
      assign wr_ptr_nx = wr_ptr + 1'b1;
      assign rd_ptr_nx = rd_ptr + 1'b1;
    end else begin : g_npow2
      assign wr_ptr_nx = (wr_ptr == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
      assign rd_ptr_nx = (rd_ptr == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (push && !clr) begin
      mem[wr_ptr] <= wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt_q  <= '0;
    end else if (clr) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt_q  <= '0;
    end else begin
      if (push) wr_ptr <= wr_ptr_nx;
      if (pop)  rd_ptr <= rd_ptr_nx;
      case ({push, pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  assign rdata = mem[rd_ptr];
  assign level = cnt_q;
  assign full  = (cnt_q == LVL_W'(DEPTH));
  assign empty = (cnt_q == '0);

endmodule

// File: rtl/gather_idle_timer.sv
module gather_idle_timer #(
  parameter int IDLE_CYCLES = 168,
  localparam int CNT_W = $clog2(IDLE_CYCLES + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic push,
  input  logic empty,
  output logic expired
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (clr || push || empty) begin
      cnt_q <= '0;
    end else if (cnt_q != CNT_W'(IDLE_CYCLES)) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign expired = !empty && (cnt_q == CNT_W'(IDLE_CYCLES));

endmodule

// File: rtl/in_pkt_streamer.sv
module in_pkt_streamer
  import usb_in_gather_pkg::*;
#(
  parameter int DEPTH   = 32,
  parameter int PKT_MAX = 32,
  localparam int LVL_W = $clog2(DEPTH + 1),
  localparam int REM_W = $clog2(PKT_MAX + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             loopback_en,
  input  logic [LVL_W-1:0] level,
  input  logic             empty,
  input  logic             gather_done,
  input  logic             in_req,
  input  logic             pkt_ready,
  input  logic             lb_ready,
  output logic             pkt_rdy,
  output logic             in_nak,
  output logic             pkt_valid,
  output logic             pkt_last,
  output logic             lb_valid,
  output logic             pop
);

  gather_state_e    state_q;
  logic [REM_W-1:0] rem_q;
  logic             nak_q;
  logic             full_pkt;
  logic             can_send;
  logic             send_pop;
  logic [REM_W-1:0] start_len;

  assign full_pkt  = (int'(level) >= PKT_MAX);
  assign can_send  = (full_pkt || gather_done) && !loopback_en;
  assign pkt_rdy   = can_send && (state_q == GS_IDLE);
  assign start_len = REM_W'(min_u(int'(level), PKT_MAX));

  assign pkt_valid = (state_q == GS_SEND);
  assign pkt_last  = pkt_valid && (rem_q == REM_W'(1));
  assign send_pop  = pkt_valid && pkt_ready;

  assign lb_valid  = loopback_en && (state_q == GS_IDLE) && !empty;
  assign pop       = send_pop || (lb_valid && lb_ready);
  assign in_nak    = nak_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= GS_IDLE;
      rem_q   <= '0;
      nak_q   <= 1'b0;
    end else if (clr) begin
      state_q <= GS_IDLE;
      rem_q   <= '0;
      nak_q   <= 1'b0;
    end else begin
      nak_q <= 1'b0;
      unique case (state_q)
        GS_IDLE: begin
          if (in_req) begin
            if (pkt_rdy) begin
              state_q <= GS_SEND;
              rem_q   <= start_len;
            end else begin
              nak_q <= 1'b1;
            end
          end
        end
        GS_SEND: begin
          if (send_pop) begin
            rem_q <= rem_q - 1'b1;
            if (rem_q == REM_W'(1)) state_q <= GS_IDLE;
          end
        end
        default: state_q <= GS_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/usb_in_gather.sv
module usb_in_gather #(
  parameter int DATA_W      = 8,
  parameter int DEPTH       = 32,
  parameter int PKT_MAX     = 32,
  parameter int IDLE_CYCLES = 168,
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  input  logic [DATA_W-1:0] wr_data,
  output logic              wr_ready,
  input  logic              fifo_clr,
  input  logic              loopback_en,
  output logic [LVL_W-1:0]  level,
  output logic              full,
  output logic              empty,
  output logic              overflow,
  output logic              pkt_rdy,
  input  logic              in_req,
  output logic              in_nak,
  output logic              pkt_valid,
  output logic [DATA_W-1:0] pkt_data,
  output logic              pkt_last,
  input  logic              pkt_ready,
  output logic              lb_valid,
  output logic [DATA_W-1:0] lb_data,
  input  logic              lb_ready
);

  logic              push;
  logic              pop;
  logic              gather_done;
  logic              ovf_q;
  logic [DATA_W-1:0] head;

  assign wr_ready = !full;
  assign push     = wr_valid && !full && !fifo_clr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ovf_q <= 1'b0;
    else        ovf_q <= wr_valid && full && !fifo_clr;
  end
  assign overflow = ovf_q;

  tx_byte_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_fifo (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (fifo_clr),
    .push  (push),
    .wdata (wr_data),
    .pop   (pop),
    .rdata (head),
    .level (level),
    .full  (full),
    .empty (empty)
  );

  gather_idle_timer #(.IDLE_CYCLES(IDLE_CYCLES)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (fifo_clr),
    .push    (push),
    .empty   (empty),
    .expired (gather_done)
  );

  in_pkt_streamer #(.DEPTH(DEPTH), .PKT_MAX(PKT_MAX)) u_stream (
    .clk         (clk),
    .rst_n       (rst_n),
    .clr         (fifo_clr),
    .loopback_en (loopback_en),
    .level       (level),
    .empty       (empty),
    .gather_done (gather_done),
    .in_req      (in_req),
    .pkt_ready   (pkt_ready),
    .lb_ready    (lb_ready),
    .pkt_rdy     (pkt_rdy),
    .in_nak      (in_nak),
    .pkt_valid   (pkt_valid),
    .pkt_last    (pkt_last),
    .lb_valid    (lb_valid),
    .pop         (pop)
  );

  assign pkt_data = head;
  assign lb_data  = head;

endmodule

// File: rtl/usb_in_gather_chk.sv
module usb_in_gather_chk #(
  parameter int DATA_W  = 8,
  parameter int DEPTH   = 32,
  parameter int PKT_MAX = 32,
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_valid,
  input logic              wr_ready,
  input logic              fifo_clr,
  input logic              loopback_en,
  input logic [LVL_W-1:0]  level,
  input logic              overflow,
  input logic              pkt_rdy,
  input logic              in_req,
  input logic              in_nak,
  input logic              pkt_valid,
  input logic [DATA_W-1:0] pkt_data,
  input logic              pkt_last,
  input logic              pkt_ready,
  input logic              lb_valid,
  input logic              lb_ready
);

  logic any_pop;
  assign any_pop = (pkt_valid && pkt_ready) || (lb_valid && lb_ready);

  // R3
  overflow_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_ready && !fifo_clr) |=> overflow);

  // R3
  overflow_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_valid && !wr_ready) |=> !overflow);

  // R2
  level_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_ready && !fifo_clr && !any_pop) |=> (level == $past(level) + 1'b1));

  // R4
  full_pkt_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(level) >= PKT_MAX && !loopback_en && !pkt_valid) |-> pkt_rdy);

  // R6
  nak_answer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_req && !pkt_rdy && !pkt_valid && !fifo_clr) |=> (in_nak && !pkt_valid));

  // R7
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_valid && !pkt_ready && !fifo_clr) |=>
      (pkt_valid && $stable(pkt_data) && $stable(pkt_last)));

  // R7
  last_ends_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_valid && pkt_ready && pkt_last) |=> !pkt_valid);

  // R9
  loopback_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    loopback_en |-> (!pkt_rdy && !(lb_valid && pkt_valid)));

  // R10
  clear_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_clr |=> (!pkt_valid && level == '0));

endmodule

bind usb_in_gather usb_in_gather_chk #(
  .DATA_W(DATA_W), .DEPTH(DEPTH), .PKT_MAX(PKT_MAX)
) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
  .fifo_clr(fifo_clr), .loopback_en(loopback_en), .level(level),
  .overflow(overflow), .pkt_rdy(pkt_rdy), .in_req(in_req), .in_nak(in_nak),
  .pkt_valid(pkt_valid), .pkt_data(pkt_data), .pkt_last(pkt_last),
  .pkt_ready(pkt_ready), .lb_valid(lb_valid), .lb_ready(lb_ready)
);

// File: tb/tb_usb_in_gather.sv
`timescale 1ns/1ps
module tb_usb_in_gather;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_valid = 1'b0;
  logic [7:0] wr_data = '0;
  logic       wr_ready;
  logic       fifo_clr = 1'b0;
  logic       loopback_en = 1'b0;
  logic [5:0] level;
  logic       full, empty, overflow, pkt_rdy;
  logic       in_req = 1'b0;
  logic       in_nak, pkt_valid, pkt_last;
  logic [7:0] pkt_data;
  logic       pkt_ready = 1'b0;
  logic       lb_valid;
  logic [7:0] lb_data;
  logic       lb_ready = 1'b0;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  usb_in_gather dut (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_data(wr_data),
    .wr_ready(wr_ready), .fifo_clr(fifo_clr), .loopback_en(loopback_en),
    .level(level), .full(full), .empty(empty), .overflow(overflow),
    .pkt_rdy(pkt_rdy), .in_req(in_req), .in_nak(in_nak),
    .pkt_valid(pkt_valid), .pkt_data(pkt_data), .pkt_last(pkt_last),
    .pkt_ready(pkt_ready), .lb_valid(lb_valid), .lb_data(lb_data),
    .lb_ready(lb_ready)
  );

  // Stimulus table: bytes written, idle edges after the last write, expected pkt_rdy.
  localparam int NVEC = 6;
  localparam int VEC_N   [NVEC] = '{1,   1,   5,  32, 31,  20};
  localparam int VEC_W   [NVEC] = '{168, 167, 168, 0, 100, 168};
  localparam bit VEC_RDY [NVEC] = '{1,   0,   1,  1,  0,   1};

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic write_burst(input int n, input int base);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      wr_valid = 1'b1;
      wr_data  = 8'(base + i);
      @(posedge clk);
    end
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic issue_in();
    @(negedge clk);
    in_req = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_req = 1'b0;
  endtask

  // Consume a packet from the current negedge; returns byte count and data errors.
  task automatic collect(input int base, output int n, output int errs);
    bit fin = 1'b0;
    n = 0;
    errs = 0;
    pkt_ready = 1'b1;
    while (!fin && n < 40) begin
      if (!pkt_valid) break;
      if (pkt_data != 8'(base + n)) errs++;
      if (pkt_last) fin = 1'b1;
      n++;
      @(posedge clk);
      @(negedge clk);
    end
    pkt_ready = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    int n, errs;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check(level == 0 && empty && !full, "R1 level/empty", int'(level), 0);
    check(!pkt_rdy && !pkt_valid && !lb_valid && !in_nak && !overflow && wr_ready,
          "R1 outputs idle", int'(pkt_rdy), 0);

    // Vector table: gathering, NAK, packet streaming
    for (int v = 0; v < NVEC; v++) begin
      int base = 16 * v + 3;
      write_burst(VEC_N[v], base);
      check(int'(level) == VEC_N[v], "R2 level after writes", int'(level), VEC_N[v]);
      repeat (VEC_W[v]) @(posedge clk);
      #1;
      if (VEC_N[v] == 32)
        check(pkt_rdy == 1'b1, "R4 full packet ready", int'(pkt_rdy), 1);
      else
        check(pkt_rdy == VEC_RDY[v], "R5 gather timer", int'(pkt_rdy), int'(VEC_RDY[v]));
      issue_in();
      if (!VEC_RDY[v]) begin
        check(in_nak && !pkt_valid, "R6 NAK when not ready", int'(in_nak), 1);
        repeat (200) @(posedge clk);
        issue_in();
      end
      check(pkt_valid == 1'b1, "R7 stream starts", int'(pkt_valid), 1);
      collect(base, n, errs);
      check(n == VEC_N[v], "R7 packet length", n, VEC_N[v]);
      check(errs == 0, "R7 byte order", errs, 0);
      check(empty == 1'b1, "R7 drained", int'(level), 0);
    end

    // R3 overflow: fill, then one extra write
    write_burst(32, 100);
    check(full && !wr_ready, "R2 full flag", int'(full), 1);
    @(negedge clk);
    wr_valid = 1'b1;
    wr_data  = 8'hEE;
    @(posedge clk);
    @(negedge clk);
    wr_valid = 1'b0;
    check(overflow == 1'b1, "R3 overflow pulse", int'(overflow), 1);
    check(int'(level) == 32, "R3 level unchanged", int'(level), 32);
    @(negedge clk);
    check(overflow == 1'b0, "R3 overflow one cycle", int'(overflow), 0);
    issue_in();
    collect(100, n, errs);
    check(n == 32 && errs == 0, "R3 dropped byte absent", errs, 0);

    // R5 restart of gathering by a later write
    write_burst(1, 60);
    repeat (100) @(posedge clk);
    write_burst(1, 61);
    repeat (167) @(posedge clk);
    #1;
    check(pkt_rdy == 1'b0, "R5 restart not yet", int'(pkt_rdy), 0);
    @(posedge clk);
    #1;
    check(pkt_rdy == 1'b1, "R5 restart expires", int'(pkt_rdy), 1);
    issue_in();
    collect(60, n, errs);
    check(n == 2 && errs == 0, "R5 gathered pair", n, 2);

    // R7 stall hold, R8 writes during transfer go to next packet
    write_burst(3, 200);
    repeat (168) @(posedge clk);
    issue_in();
    check(pkt_data == 8'd200, "R7 first byte", int'(pkt_data), 200);
    write_burst(2, 203);
    check(pkt_valid && pkt_data == 8'd200, "R7 stall hold", int'(pkt_data), 200);
    collect(200, n, errs);
    check(n == 3 && errs == 0, "R8 latched length", n, 3);
    check(int'(level) == 2, "R8 leftover bytes", int'(level), 2);
    repeat (170) @(posedge clk);
    issue_in();
    collect(203, n, errs);
    check(n == 2 && errs == 0, "R8 next packet", n, 2);

    // R9 loopback
    @(negedge clk);
    loopback_en = 1'b1;
    write_burst(4, 40);
    repeat (200) @(posedge clk);
    #1;
    check(pkt_rdy == 1'b0, "R9 no USB packet", int'(pkt_rdy), 0);
    issue_in();
    check(in_nak && !pkt_valid, "R9 NAK in loopback", int'(in_nak), 1);
    lb_ready = 1'b1;
    errs = 0;
    for (int i = 0; i < 4; i++) begin
      if (!lb_valid || lb_data != 8'(40 + i)) errs++;
      @(posedge clk);
      @(negedge clk);
    end
    lb_ready = 1'b0;
    check(errs == 0, "R9 loopback order", errs, 0);
    check(empty && !lb_valid, "R9 loopback drained", int'(level), 0);
    loopback_en = 1'b0;

    // R10 clear while idle and during a transfer
    write_burst(5, 70);
    @(negedge clk);
    fifo_clr = 1'b1;
    @(negedge clk);
    fifo_clr = 1'b0;
    check(empty && level == 0, "R10 clear empties", int'(level), 0);
    write_burst(3, 80);
    repeat (168) @(posedge clk);
    issue_in();
    check(pkt_valid == 1'b1, "R10 send started", int'(pkt_valid), 1);
    fifo_clr = 1'b1;
    @(negedge clk);
    fifo_clr = 1'b0;
    check(!pkt_valid && empty, "R10 abort transfer", int'(pkt_valid), 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule